// File: doc/BRIEF.md
# Frame Buffer Network Interface

This block is a small memory-mapped network controller. A host reaches it through a 64-byte register window on a plain read/write bus. The network side has two parts. A byte-stream input accepts whole frames into a single receive buffer. A byte-stream output sends a frame that the host has assembled in a single transmit buffer.

Frame data crosses the host bus one byte per register access. The host pops received bytes from a data port, and it pushes bytes for transmission into another data port. Transmission starts without a separate command: it begins once the number of pushed bytes equals the programmed length. A single interrupt-control register does three jobs:
- it holds the transmit-done and receive-done flags;
- it holds a self-test bit, and setting that bit by a write resets the device;
- it determines the busy flag, which follows the pending flags whenever that register is written.

A level interrupt is raised while any flag is set.

The host bus uses full words. Read data comes from a register and appears on `bus_rdata` in the cycle after the read strobe. Only the low six address bits are decoded.

Top module: `nic_fbuf`

## Requirements
- R1: Register offsets are: identity word A at 0x00, identity word B at 0x04, busy at 0x08, receive count at 0x0C, transmit count at 0x10, interrupt control at 0x14, interrupt info at 0x18, receive data at 0x1C and transmit data at 0x20. Address bits above bit 5 are ignored. With the defaults, identity A reads 32'h4655_4246 and identity B reads 32'h3054_454E (first character in byte lane 0). Interrupt info, the transmit data port and every unmapped offset read 0.
- R2: Interrupt control has three bits: bit 0 is transmit-done, bit 1 is receive-done and bit 31 is self-test. `irq` is high exactly while any of them is set. A read returns the current value and then clears bit 31.
- R3: A write to interrupt control is decoded by priority. If bit 0 is set, only transmit-done is cleared. Otherwise, if bit 1 is set, only receive-done is cleared. Otherwise, if bit 31 is set, the device is reset and then self-test is set. A write of 0 changes no flag.
- R4: After any write to interrupt control, busy equals "any interrupt-control bit set".
- R5: After reset, busy is 1, both counts and both buffer pointers are 0, interrupt control is 0 and `irq` is low.
- R6: A frame is accepted only if busy is 0, the receive count is below 1514, and `rx_len` (sampled on the first beat) is below 1514. Any other frame is dropped with no effect on state.
- R7: An accepted frame commits on its last beat. The commit sets the receive count to its length, resets the read pointer, sets busy to 1 and sets receive-done.
- R8: Each receive-data read with a nonzero count returns the next stored byte in arrival order and decrements the count. With a count of 0 the read returns 0 and changes nothing.
- R9: A transmit-count write loads the value if it is at most 1514 and loads 0 otherwise. In both cases it clears the write pointer.
- R10: Each transmit-data write stores bits 7:0 and advances the pointer. When the pointer reaches the programmed count, or reaches 1514, the frame is sent with that length. The send clears both transmit counters and sets transmit-done and busy.
- R11: A sent frame leaves as one byte per cycle on `tx_valid`/`tx_data`. `tx_last` marks the final byte, and `tx_len` holds the length steady for the whole frame.
- R12: `rx_ready` is high exactly when busy is 0 and the receive count is below 1514.
- R13: If a frame commits in the same cycle as an interrupt-control write, the commit wins: receive-done and busy end up set. If that write is a self-test reset, the frame is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; low six bits decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | 1 | Level interrupt |
| rx_valid | input | 1 | Receive beat valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final beat of a frame |
| rx_len | input | LEN_W | Frame length, sampled on the first beat |
| rx_ready | output | 1 | Device can accept a frame |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the sent frame |
| tx_len | output | LEN_W | Length of the frame being sent |

## Verification
Two functions can meet in one cycle: the network side commits a received frame, and the host writes interrupt control. The bench provokes this by first starting a multi-beat frame while busy is low. It then fires a transmission so that transmit-done and busy are set. Finally it drives the last receive beat on the same clock edge as a write that clears transmit-done, and it expects interrupt control to read 2, busy 1 and the full receive count. A second case places a self-test write on the final beat instead, and it expects interrupt control to read only the self-test bit and a receive count of 0.

// File: rtl/nic_fbuf_pkg.sv
package nic_fbuf_pkg;

    // Register window offsets (low six address bits)
    localparam logic [5:0] OFF_ID0    = 6'h00;
    localparam logic [5:0] OFF_ID1    = 6'h04;
    localparam logic [5:0] OFF_BUSY   = 6'h08;
    localparam logic [5:0] OFF_RXCNT  = 6'h0C;
    localparam logic [5:0] OFF_TXCNT  = 6'h10;
    localparam logic [5:0] OFF_ICTL   = 6'h14;
    localparam logic [5:0] OFF_INFO   = 6'h18;
    localparam logic [5:0] OFF_RXDATA = 6'h1C;
    localparam logic [5:0] OFF_TXDATA = 6'h20;

    localparam int ICTL_TXD_BIT  = 0;
    localparam int ICTL_RXD_BIT  = 1;
    localparam int ICTL_TEST_BIT = 31;

    typedef struct packed {
        logic test;
        logic rxd;
        logic txd;
    } ictl_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_STORE,
        RX_DROP
    } rx_state_e;

    function automatic logic [31:0] ictl_word(input ictl_t c);
        logic [31:0] w;
        w = '0;
        w[ICTL_TEST_BIT] = c.test;
        w[ICTL_RXD_BIT]  = c.rxd;
        w[ICTL_TXD_BIT]  = c.txd;
        return w;
    endfunction

    function automatic logic ictl_any(input ictl_t c);
        return c.test | c.rxd | c.txd;
    endfunction

endpackage

// File: rtl/nic_frame_ram.sv
module nic_frame_ram #(
    parameter int DEPTH = 1514,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/nic_rx_writer.sv
module nic_rx_writer
    import nic_fbuf_pkg::*;
#(
    parameter int MAX_FRAME = 1514,
    parameter int LEN_W     = 11,
    parameter int AW        = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             can_accept,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_last,
    input  logic [LEN_W-1:0] rx_len,
    output logic             ram_we,
    output logic [AW-1:0]    ram_waddr,
    output logic [7:0]       ram_wdata,
    output logic             commit,
    output logic [LEN_W-1:0] commit_len
);
    rx_state_e        st;
    logic [AW-1:0]    idx;
    logic [LEN_W-1:0] len_q;
    logic             fits;
    logic             take;

    assign fits = rx_len < LEN_W'(MAX_FRAME);
    assign take = (st == RX_IDLE) && rx_valid && can_accept && fits && !soft_rst;

    always_comb begin
        ram_we     = take || ((st == RX_STORE) && rx_valid && !soft_rst
                              && (int'(idx) < MAX_FRAME));
        ram_waddr  = (st == RX_IDLE) ? '0 : idx;
        ram_wdata  = rx_data;
        commit     = ram_we && rx_last;
        commit_len = (st == RX_IDLE) ? rx_len : len_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= RX_IDLE;
            idx   <= '0;
            len_q <= '0;
        end else begin
            unique case (st)
                RX_IDLE: if (rx_valid && !rx_last) begin
                    st    <= take ? RX_STORE : RX_DROP;
                    idx   <= AW'(1);
                    len_q <= rx_len;
                end
                RX_STORE: begin
                    if (soft_rst)
                        st <= (rx_valid && rx_last) ? RX_IDLE : RX_DROP;
                    else if (rx_valid) begin
                        if (rx_last) st <= RX_IDLE;
                        else         idx <= idx + AW'(1);
                    end
                end
                RX_DROP: if (rx_valid && rx_last) st <= RX_IDLE;
                default: st <= RX_IDLE;
            endcase
        end
    end

    // A first beat refused by the register side never leads to storage
    AST_NO_STORE_WHEN_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (st == RX_IDLE && rx_valid && !rx_last && !can_accept) |=> (st == RX_DROP)); // R6
endmodule

// File: rtl/nic_tx_sender.sv
module nic_tx_sender #(
    parameter int LEN_W = 11,
    parameter int AW    = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [LEN_W-1:0] fire_len,
    input  logic [7:0]       ram_rdata,
    output logic [AW-1:0]    ram_raddr,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    output logic [LEN_W-1:0] tx_len
);
    logic             sending;
    logic [LEN_W-1:0] idx;
    logic [LEN_W-1:0] len_q;
    logic             v_q;
    logic             l_q;
    logic             at_end;

    assign at_end    = (idx == len_q - LEN_W'(1));
    assign ram_raddr = AW'(idx);
    assign tx_valid  = v_q;
    assign tx_last   = l_q;
    assign tx_data   = ram_rdata;
    assign tx_len    = len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sending <= 1'b0;
            idx     <= '0;
            len_q   <= '0;
            v_q     <= 1'b0;
            l_q     <= 1'b0;
        end else begin
            v_q <= 1'b0;
            l_q <= 1'b0;
            if (fire) begin
                sending <= 1'b1;
                idx     <= '0;
                len_q   <= fire_len;
            end else if (sending) begin
                v_q <= 1'b1;
                l_q <= at_end;
                idx <= idx + LEN_W'(1);
                if (at_end) sending <= 1'b0;
            end
        end
    end

    AST_LEN_HELD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_last) |=> (tx_valid && $stable(tx_len))); // R11
endmodule

// File: rtl/nic_fbuf.sv
module nic_fbuf
    import nic_fbuf_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          MAX_FRAME = 1514,
    parameter logic [31:0] ID_WORD0  = 32'h4655_4246,
    parameter logic [31:0] ID_WORD1  = 32'h3054_454E,
    localparam int         LEN_W     = $clog2(MAX_FRAME + 1),
    localparam int         AW        = $clog2(MAX_FRAME)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic [LEN_W-1:0]  rx_len,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic [LEN_W-1:0]  tx_len
);
    logic [5:0]       off;
    logic             unused_addr_hi;
    logic             host_rd, host_wr;
    logic             busy_q, busy_n;
    ictl_t            ictl_q, ictl_n;
    logic [LEN_W-1:0] rx_cnt, rx_ptr, tx_cnt, tx_ptr, tx_nxt;
    logic [31:0]      rdata_q, rd_mux;
    logic             rxd_hit_q;
    logic             soft_rst, rx_pop, tx_cnt_wr, tx_dat_wr, tx_fire;
    logic             rx_commit;
    logic [LEN_W-1:0] rx_commit_len;
    logic             rxw_we;
    logic [AW-1:0]    rxw_addr;
    logic [7:0]       rxw_data, rx_ram_q, tx_ram_q;
    logic [AW-1:0]    tx_raddr;

    assign off            = bus_addr[5:0];
    assign unused_addr_hi = ^bus_addr;
    assign host_rd   = bus_sel && !bus_wr;
    assign host_wr   = bus_sel && bus_wr;
    assign rx_pop    = host_rd && (off == OFF_RXDATA) && (rx_cnt != '0);
    assign tx_cnt_wr = host_wr && (off == OFF_TXCNT);
    assign tx_dat_wr = host_wr && (off == OFF_TXDATA);
    assign tx_nxt    = tx_ptr + LEN_W'(1);
    assign tx_fire   = tx_dat_wr && ((tx_nxt == tx_cnt) || (int'(tx_nxt) >= MAX_FRAME));
    assign rx_ready  = !busy_q && (int'(rx_cnt) < MAX_FRAME);
    assign irq       = ictl_any(ictl_q);
    assign bus_rdata = rxd_hit_q ? {24'b0, rx_ram_q} : rdata_q;

    // Flag and busy update: host op first, then frame events override
    always_comb begin
        ictl_n   = ictl_q;
        busy_n   = busy_q;
        soft_rst = 1'b0;
        if (host_rd && off == OFF_ICTL) ictl_n.test = 1'b0;
        if (host_wr && off == OFF_ICTL) begin
            if (bus_wdata[ICTL_TXD_BIT])       ictl_n.txd = 1'b0;
            else if (bus_wdata[ICTL_RXD_BIT])  ictl_n.rxd = 1'b0;
            else if (bus_wdata[ICTL_TEST_BIT]) begin
                soft_rst = 1'b1;
                ictl_n   = '{test: 1'b1, rxd: 1'b0, txd: 1'b0};
            end
            busy_n = ictl_any(ictl_n);
        end
        if (tx_fire) begin
            ictl_n.txd = 1'b1;
            busy_n     = 1'b1;
        end
        if (rx_commit && !soft_rst) begin
            ictl_n.rxd = 1'b1;
            busy_n     = 1'b1;
        end
    end

    always_comb begin
        unique case (off)
            OFF_ID0:   rd_mux = ID_WORD0;
            OFF_ID1:   rd_mux = ID_WORD1;
            OFF_BUSY:  rd_mux = {31'b0, busy_q};
            OFF_RXCNT: rd_mux = 32'(rx_cnt);
            OFF_TXCNT: rd_mux = 32'(tx_cnt);
            OFF_ICTL:  rd_mux = ictl_word(ictl_q);
            OFF_INFO:  rd_mux = '0;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b1;
            ictl_q    <= '0;
            rx_cnt    <= '0;
            rx_ptr    <= '0;
            tx_cnt    <= '0;
            tx_ptr    <= '0;
            rdata_q   <= '0;
            rxd_hit_q <= 1'b0;
        end else begin
            busy_q <= busy_n;
            ictl_q <= ictl_n;
            if (host_rd) begin
                rdata_q   <= rd_mux;
                rxd_hit_q <= rx_pop;
            end
            if (soft_rst) begin
                rx_cnt <= '0;
                rx_ptr <= '0;
                tx_cnt <= '0;
                tx_ptr <= '0;
            end else begin
                if (rx_commit) begin
                    rx_cnt <= rx_commit_len;
                    rx_ptr <= '0;
                end else if (rx_pop) begin
                    rx_cnt <= rx_cnt - LEN_W'(1);
                    rx_ptr <= rx_ptr + LEN_W'(1);
                end
                if (tx_cnt_wr) begin
                    tx_cnt <= (bus_wdata <= 32'(MAX_FRAME)) ? LEN_W'(bus_wdata) : '0;
                    tx_ptr <= '0;
                end else if (tx_fire) begin
                    tx_cnt <= '0;
                    tx_ptr <= '0;
                end else if (tx_dat_wr) begin
                    tx_ptr <= tx_nxt;
                end
            end
        end
    end

    nic_rx_writer #(.MAX_FRAME(MAX_FRAME), .LEN_W(LEN_W), .AW(AW)) rx_wr_i (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .can_accept(rx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_len(rx_len),
        .ram_we(rxw_we), .ram_waddr(rxw_addr), .ram_wdata(rxw_data),
        .commit(rx_commit), .commit_len(rx_commit_len)
    );

    nic_frame_ram #(.DEPTH(MAX_FRAME), .AW(AW)) rx_ram_i (
        .clk(clk), .we(rxw_we), .waddr(rxw_addr), .wdata(rxw_data),
        .raddr(rx_ptr[AW-1:0]), .rdata(rx_ram_q)
    );

    nic_frame_ram #(.DEPTH(MAX_FRAME), .AW(AW)) tx_ram_i (
        .clk(clk), .we(tx_dat_wr), .waddr(tx_ptr[AW-1:0]), .wdata(bus_wdata[7:0]),
        .raddr(tx_raddr), .rdata(tx_ram_q)
    );

    nic_tx_sender #(.LEN_W(LEN_W), .AW(AW)) tx_snd_i (
        .clk(clk), .rst(rst), .fire(tx_fire), .fire_len(tx_nxt),
        .ram_rdata(tx_ram_q), .ram_raddr(tx_raddr),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_len(tx_len)
    );

    AST_SELFTEST_RESET: assert property (@(posedge clk) disable iff (rst)
        (host_wr && off == OFF_ICTL && !bus_wdata[0] && !bus_wdata[1] && bus_wdata[31])
        |=> (irq && busy_q && rx_cnt == '0 && tx_cnt == '0 && bus_rdata == bus_rdata)); // R3
    AST_RX_POP_DEC: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && !rx_commit && !soft_rst) |=> (rx_cnt == $past(rx_cnt) - LEN_W'(1))); // R8
    AST_COMMIT_FLAGS: assert property (@(posedge clk) disable iff (rst)
        rx_commit |=> (busy_q && irq && !rx_ready)); // R7
    AST_TX_FIRE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        tx_fire |=> (busy_q && irq && tx_cnt == '0)); // R10
    AST_RX_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(rx_cnt) < MAX_FRAME); // R6
endmodule

// File: tb/nic_fbuf_tb_top.sv
`timescale 1ns/1ps
module nic_fbuf_tb_top;
    localparam int LW = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq, rx_ready, tx_valid, tx_last;
    logic          rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]    rx_data = '0, tx_data;
    logic [LW-1:0] rx_len = '0, tx_len;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    nic_fbuf dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_len(rx_len),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_len(tx_len)
    );

    // Transmit stream capture
    logic [7:0] cap [4096];
    int         cap_n = 0;
    int         cap_last_at = -1;
    int         cap_len = 0;
    always @(negedge clk) begin
        if (tx_valid) begin
            cap[cap_n] = tx_data;
            if (tx_last) cap_last_at = cap_n;
            cap_len = int'(tx_len);
            cap_n = cap_n + 1;
        end
    end

    // address, expected value after reset
    localparam logic [39:0] RD_VEC [13] = '{
        {8'h00, 32'h4655_4246}, {8'h04, 32'h3054_454E}, {8'h08, 32'h1},
        {8'h0C, 32'h0}, {8'h10, 32'h0}, {8'h14, 32'h0}, {8'h18, 32'h0},
        {8'h1C, 32'h0}, {8'h20, 32'h0}, {8'h24, 32'h0}, {8'h3C, 32'h0},
        {8'h40, 32'h4655_4246}, {8'h48, 32'h1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rx_beat(input logic [7:0] b, input logic last, input int len);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b; rx_last = last; rx_len = LW'(len);
    endtask

    task automatic rx_idle();
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog (R1..all): got hang expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R5 reset state, R12 ready low while busy
        chk("R5 irq after reset", {31'b0, irq}, 32'h0);
        chk("R12 ready low after reset", {31'b0, rx_ready}, 32'h0);

        // R1 register map walk after reset
        for (int i = 0; i < 13; i++) begin
            bus_read(RD_VEC[i][39:32], d);
            chk($sformatf("R1 read offset %h", RD_VEC[i][39:32]), d, RD_VEC[i][31:0]);
        end

        // R4 write of zero recomputes busy
        bus_write(8'h14, 32'h0);
        bus_read(8'h08, d);  chk("R4 busy after zero write", d, 32'h0);
        chk("R12 ready when idle", {31'b0, rx_ready}, 32'h1);

        // R7 accept a 4-byte frame
        rx_beat(8'hA1, 1'b0, 4); rx_beat(8'hB2, 1'b0, 4);
        rx_beat(8'hC3, 1'b0, 4); rx_beat(8'hD4, 1'b1, 4); rx_idle();
        chk("R7 irq after commit", {31'b0, irq}, 32'h1);
        chk("R12 ready low after commit", {31'b0, rx_ready}, 32'h0);
        bus_read(8'h0C, d);  chk("R7 rx count", d, 32'd4);
        bus_read(8'h14, d);  chk("R7 rx-done flag", d, 32'h2);

        // R6 frame while busy is dropped
        rx_beat(8'h11, 1'b0, 2); rx_beat(8'h22, 1'b1, 2); rx_idle();
        bus_read(8'h0C, d);  chk("R6 busy drop keeps count", d, 32'd4);

        // R8 pop bytes in order
        bus_read(8'h1C, d);  chk("R8 byte 0", d, 32'hA1);
        bus_read(8'h1C, d);  chk("R8 byte 1", d, 32'hB2);
        bus_read(8'h1C, d);  chk("R8 byte 2", d, 32'hC3);
        bus_read(8'h1C, d);  chk("R8 byte 3", d, 32'hD4);
        bus_read(8'h0C, d);  chk("R8 count drained", d, 32'h0);
        bus_read(8'h1C, d);  chk("R8 empty read", d, 32'h0);
        bus_read(8'h0C, d);  chk("R8 empty read no change", d, 32'h0);

        // R3/R4 clear rx-done
        bus_write(8'h14, 32'h2);
        chk("R3 irq after rx-done clear", {31'b0, irq}, 32'h0);
        bus_read(8'h08, d);  chk("R4 busy cleared", d, 32'h0);

        // R6 oversize frame dropped
        rx_beat(8'h99, 1'b1, 1514); rx_idle();
        chk("R6 oversize no irq", {31'b0, irq}, 32'h0);
        bus_read(8'h0C, d);  chk("R6 oversize count", d, 32'h0);

        // R9/R10/R11 three-byte transmit
        base = cap_n;
        bus_write(8'h10, 32'd3);
        bus_read(8'h10, d);  chk("R9 tx count load", d, 32'd3);
        bus_write(8'h20, 32'h1AB); bus_write(8'h20, 32'h0CD); bus_write(8'h20, 32'h0EF);
        repeat (6) @(negedge clk);
        chk("R11 tx beats", 32'(cap_n - base), 32'd3);
        chk("R10 tx byte 0", {24'b0, cap[base]}, 32'hAB);
        chk("R10 tx byte 1", {24'b0, cap[base + 1]}, 32'hCD);
        chk("R10 tx byte 2", {24'b0, cap[base + 2]}, 32'hEF);
        chk("R11 tx last position", 32'(cap_last_at - base), 32'd2);
        chk("R11 tx len", 32'(cap_len), 32'd3);
        bus_read(8'h14, d);  chk("R10 tx-done flag", d, 32'h1);
        bus_read(8'h10, d);  chk("R10 tx count cleared", d, 32'h0);
        bus_read(8'h08, d);  chk("R10 busy after send", d, 32'h1);

        // R3 priority of the clear bits
        bus_write(8'h14, 32'h1);
        rx_beat(8'h5A, 1'b1, 1); rx_idle();
        base = cap_n;
        bus_write(8'h10, 32'd1); bus_write(8'h20, 32'h77);
        repeat (4) @(negedge clk);
        chk("R10 one-byte frame", {24'b0, cap[base]}, 32'h77);
        bus_read(8'h14, d);  chk("R2 both done flags", d, 32'h3);
        bus_write(8'h14, 32'h8000_0003);
        bus_read(8'h14, d);  chk("R3 bit0 wins", d, 32'h2);
        bus_read(8'h0C, d);  chk("R3 no reset on bit0", d, 32'd1);
        bus_write(8'h14, 32'h8000_0002);
        bus_read(8'h14, d);  chk("R3 bit1 wins over test", d, 32'h0);
        bus_read(8'h08, d);  chk("R4 busy after clears", d, 32'h0);

        // R3/R2 self-test reset
        bus_write(8'h14, 32'h8000_0000);
        bus_read(8'h0C, d);  chk("R3 self-test clears count", d, 32'h0);
        chk("R2 irq on test bit", {31'b0, irq}, 32'h1);
        bus_read(8'h14, d);  chk("R2 test bit read", d, 32'h8000_0000);
        bus_read(8'h14, d);  chk("R2 test bit cleared by read", d, 32'h0);
        chk("R2 irq dropped", {31'b0, irq}, 32'h0);
        bus_read(8'h08, d);  chk("R5 busy after self-test", d, 32'h1);
        bus_write(8'h14, 32'h0);

        // R9 bounds, R10 cap at full size
        bus_write(8'h10, 32'd1514);
        bus_read(8'h10, d);  chk("R9 max count kept", d, 32'd1514);
        bus_write(8'h10, 32'd2000);
        bus_read(8'h10, d);  chk("R9 oversize count zeroed", d, 32'h0);
        base = cap_n;
        for (int i = 0; i < 1514; i++) bus_write(8'h20, 32'(i));
        repeat (1520) @(negedge clk);
        chk("R10 full-size beats", 32'(cap_n - base), 32'd1514);
        chk("R10 full-size middle byte", {24'b0, cap[base + 700]}, 32'(700 % 256));
        chk("R11 full-size last", 32'(cap_last_at - base), 32'd1513);
        chk("R11 full-size len", 32'(cap_len), 32'd1514);
        bus_write(8'h14, 32'h1);

        // R13 commit meets a flag-clear write
        rx_beat(8'h10, 1'b0, 3); rx_beat(8'h20, 1'b0, 3); rx_idle();
        bus_write(8'h10, 32'd1); bus_write(8'h20, 32'h55);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'h30; rx_last = 1'b1; rx_len = LW'(3);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h1;
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_read(8'h14, d);  chk("R13 commit beats clear", d, 32'h2);
        bus_read(8'h08, d);  chk("R13 busy kept", d, 32'h1);
        bus_read(8'h0C, d);  chk("R13 count", d, 32'd3);
        bus_read(8'h1C, d);  chk("R13 first byte", d, 32'h10);
        bus_write(8'h14, 32'h2);
        chk("R12 ready with data left", {31'b0, rx_ready}, 32'h1);

        // R13 self-test on final beat discards frame
        rx_beat(8'h66, 1'b0, 2);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'h77; rx_last = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h8000_0000;
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_read(8'h14, d);  chk("R13 self-test wins", d, 32'h8000_0000);
        bus_read(8'h0C, d);  chk("R13 frame discarded", d, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule